// File: doc/BRIEF.md
# Network Controller Interrupt Cause and Mask Unit

This block gathers the one-cycle event strobes raised by a network controller's transmit path, receive path and link monitor and latches each strobe into a sticky cause register. A mask register picks which causes may reach the host. The block drives one level-sensitive interrupt line, which is high while any enabled cause is pending.

The host reaches the block over a small word-wide register bus. A 2-bit address selects one of four registers. One register returns the pending causes and clears them when it is read. One is write-only and forces cause bits for test. One sets mask bits and reads back the mask. One is write-only and clears mask bits. Causes latch whatever the mask holds, so enabling a cause that is already pending raises the line straight away. Reads return their data one cycle after the read strobe.

Top module: `nic_irq_agg`

## Requirements
- R1: A synchronous active-low reset clears the cause register, the mask register, the read data and the interrupt line.
- R2: An event strobe on cause bit 0 (transmit descriptor done), 1 (transmit queue empty), 2 (link change), 3 (receive sequence error), 4 (receive descriptors low), 6 (receive overrun) or 7 (receive timer) sets that cause bit at the next clock edge. Bit 5 is reserved and never becomes pending.
- R3: A read at address 0 returns the pending causes in data bits 7:0 in the cycle after the read strobe and clears every pending cause. Read data is zero in any cycle that does not follow a read strobe.
- R4: An event strobe that arrives in the same cycle as a cause read stays pending after the read.
- R5: A write to address 1 ORs data bits 7:0 (reserved bit 5 excluded) into the cause register. A read of address 1 returns zero.
- R6: A write to address 2 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. A read of address 2 returns the mask in bits 7:0.
- R7: A write to address 3 clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged. A read of address 3 returns zero.
- R8: Bit 31 of a cause read is 1 exactly when, at the read strobe, some pending cause is also enabled in the mask.
- R9: The interrupt output equals the OR over all bits of (cause AND mask), registered once. It rises one cycle after either an enabled cause becomes pending or a pending cause is unmasked.
- R10: A write to address 0 changes neither the causes nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 8 | One-cycle event strobes, one per cause bit |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 cause, 1 force, 2 mask set, 3 mask clear |
| wr_data_i | input | 8 | Write data for cause or mask bits |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt output |

## Verification
The cause and mask registers change at the edge that samples a strobe or a write. Read data appears one cycle after the read strobe. The interrupt line lags a cause or mask change by one more edge, so it rises two cycles after an event strobe. A behavioural model in the bench advances on the same edges and is compared against both outputs at every falling edge. Directed checks sample the interrupt line one falling edge after the register update, which keeps each comparison clear of the cycle in which the result changes.

// File: rtl/intc_pkg.sv
// Package: shared register-select encoding for the interrupt cause unit.
// Assumes a 2-bit register address on the host bus.
package intc_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CAUSE = 2'd0,   // read-to-clear pending causes
        SEL_FORCE = 2'd1,   // write-only cause force
        SEL_MSET  = 2'd2,   // mask set, reads back the mask
        SEL_MCLR  = 2'd3    // write-only mask clear
    } reg_sel_e;
endpackage

// File: rtl/intc_host_port.sv
// Module: intc_host_port
// Decodes host read/write strobes into register actions and registers read data.
// Assumes at most one of rd_en_i / wr_en_i per cycle; read data is zero unless
// it follows a read strobe.
module intc_host_port
    import intc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   addr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [CAUSE_W-1:0] mask_i,
    output logic               cause_clr_o,
    output logic               force_we_o,
    output logic               mset_we_o,
    output logic               mclr_we_o,
    output logic [DATA_W-1:0]  rd_data_o
);
    localparam int SUM_BIT = DATA_W - 1;

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;

    assign sel = reg_sel_e'(addr_i);

    // Turn strobes plus address into one-hot register actions.
    always_comb begin
        cause_clr_o = rd_en_i && (sel == SEL_CAUSE);
        force_we_o  = wr_en_i && (sel == SEL_FORCE);
        mset_we_o   = wr_en_i && (sel == SEL_MSET);
        mclr_we_o   = wr_en_i && (sel == SEL_MCLR);
    end

    // Select the value a read of the addressed register returns.
    always_comb begin
        rd_next = '0;
        case (sel)
            SEL_CAUSE: begin
                rd_next[CAUSE_W-1:0] = cause_i;
                rd_next[SUM_BIT]     = |(cause_i & mask_i);
            end
            SEL_MSET:  rd_next[CAUSE_W-1:0] = mask_i;
            default:   rd_next = '0;
        endcase
    end

    // Register read data for one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_next;
        else              rd_q <= '0;
    end

    assign rd_data_o = rd_q;

    // R5 R7
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (sel == SEL_FORCE || sel == SEL_MCLR)) |=> (rd_data_o == '0));
    // R3
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

// File: rtl/intc_cause_reg.sv
// Module: intc_cause_reg
// Sticky cause register: event strobes and forced writes set bits, a cause
// read clears them. A strobe in the same cycle as the clear wins.
// Assumes strobes are one cycle wide; reserved bits (IMPL_MASK = 0) stay 0.
module intc_cause_reg #(
    parameter int               CAUSE_W   = 8,
    parameter logic [CAUSE_W-1:0] IMPL_MASK = 8'hDF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_i,
    input  logic               clr_i,
    input  logic               force_we_i,
    input  logic [CAUSE_W-1:0] force_data_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] keep;
    logic [CAUSE_W-1:0] set_bits;

    // Combine all set sources and the read-clear into the next value.
    always_comb begin
        keep     = clr_i ? '0 : cause_q;
        set_bits = ev_i | (force_we_i ? force_data_i : '0);
    end

    // Hold pending causes until a read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (keep | set_bits) & IMPL_MASK;
    end

    assign cause_o = cause_q;

    // R2 R4
    ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & IMPL_MASK)) |=> ((cause_q & $past(ev_i & IMPL_MASK)) == $past(ev_i & IMPL_MASK)));
    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ev_i == '0 && !force_we_i) |=> (cause_q == '0));
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~IMPL_MASK) == '0));
endmodule

// File: rtl/intc_mask_reg.sv
// Module: intc_mask_reg
// Interrupt enable mask with separate set-only and clear-only write ports.
// Assumes the two write enables are never high together.
module intc_mask_reg #(
    parameter int                 CAUSE_W   = 8,
    parameter logic [CAUSE_W-1:0] IMPL_MASK = 8'hDF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we_i,
    input  logic               clr_we_i,
    input  logic [CAUSE_W-1:0] data_i,
    output logic [CAUSE_W-1:0] mask_o
);
    logic [CAUSE_W-1:0] mask_q;
    logic [CAUSE_W-1:0] bits;

    // Only implemented positions are writable.
    assign bits = data_i & IMPL_MASK;

    // Apply set-only or clear-only updates; zero data bits leave the mask alone.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (set_we_i) mask_q <= mask_q | bits;
        else if (clr_we_i) mask_q <= mask_q & ~bits;
    end

    assign mask_o = mask_q;

    // R6
    mset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((mask_q & $past(bits)) == $past(bits)));
    // R7
    mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((mask_q & $past(bits)) == '0));
    // R6 R7 R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we_i && !clr_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/nic_irq_agg.sv
// Module: nic_irq_agg
// Top of the interrupt cause and mask unit: sticky causes, a set/clear mask,
// a host register port and one registered level interrupt.
// Assumes event strobes are synchronous to clk and one cycle wide.
module nic_irq_agg
    import intc_pkg::*;
#(
    parameter int                 DATA_W    = 32,
    parameter int                 CAUSE_W   = 8,
    parameter logic [CAUSE_W-1:0] IMPL_MASK = 8'hDF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   addr_i,
    input  logic [CAUSE_W-1:0] wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o
);
    logic [CAUSE_W-1:0] cause;
    logic [CAUSE_W-1:0] mask;
    logic               cause_clr;
    logic               force_we;
    logic               mset_we;
    logic               mclr_we;
    logic               irq_q;

    intc_host_port #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (rd_en_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .cause_i     (cause),
        .mask_i      (mask),
        .cause_clr_o (cause_clr),
        .force_we_o  (force_we),
        .mset_we_o   (mset_we),
        .mclr_we_o   (mclr_we),
        .rd_data_o   (rd_data_o)
    );

    intc_cause_reg #(.CAUSE_W(CAUSE_W), .IMPL_MASK(IMPL_MASK)) u_cause (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev_i),
        .clr_i        (cause_clr),
        .force_we_i   (force_we),
        .force_data_i (wr_data_i),
        .cause_o      (cause)
    );

    intc_mask_reg #(.CAUSE_W(CAUSE_W), .IMPL_MASK(IMPL_MASK)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (mset_we),
        .clr_we_i (mclr_we),
        .data_i   (wr_data_i),
        .mask_o   (mask)
    );

    // Register the enabled-pending summary onto the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause & mask);
    end

    assign irq_o = irq_q;

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause & mask)) |=> irq_o);
    // R9
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(cause & mask)) |=> !irq_o);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && rd_data_o == '0));
endmodule

// File: tb/sim_nic_irq_agg.sv
module sim_nic_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // behavioural reference state
    logic [7:0]  m_cause, m_mask;
    logic [31:0] m_rd;
    logic        m_irq;
    bit          armed = 0;
    localparam logic [7:0] IMPL = 8'hDF;

    always #4 clk = ~clk;   // 125 MHz

    nic_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
    );

    // reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        logic [31:0] r;
        logic [7:0]  c;
        armed <= 1;
        if (!rst_n) begin
            m_cause <= '0; m_mask <= '0; m_rd <= '0; m_irq <= 0;
        end else begin
            r = 0;
            if (rd_en && addr == 2'd0) begin
                r[7:0] = m_cause;
                r[31]  = (m_cause & m_mask) != 0;
            end else if (rd_en && addr == 2'd2) begin
                r[7:0] = m_mask;
            end
            m_rd <= r;
            c = (rd_en && addr == 2'd0) ? 8'h00 : m_cause;
            c = c | ev;
            if (wr_en && addr == 2'd1) c = c | wdata;
            m_cause <= c & IMPL;
            if (wr_en && addr == 2'd2) m_mask <= m_mask | (wdata & IMPL);
            if (wr_en && addr == 2'd3) m_mask <= m_mask & ~(wdata & IMPL);
            m_irq <= (m_cause & m_mask) != 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !done) begin
            vectors++;
            if (irq !== m_irq) begin
                misses++;
                $display("FAIL R9 model irq: got %0b expected %0b at %0t", irq, m_irq, $time);
            end
            vectors++;
            if (rdata !== m_rd) begin
                misses++;
                $display("FAIL R3 model read data: got %h expected %h at %0t", rdata, m_rd, $time);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); d = rdata; rd_en = 0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); wr_en = 1; addr = a; wdata = v;
        @(negedge clk); wr_en = 0; wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk); ev = v;
        @(negedge clk); ev = '0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        do_read(2'd0, d); check("R1 cause after reset", d, 32'h0);
        do_read(2'd2, d); check("R1 mask after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R3 R8 R9 masked cause latches, read clears
        pulse(8'h01);
        @(negedge clk); check("R9 masked cause keeps irq low", {31'b0, irq}, 32'h0);
        do_read(2'd0, d); check("R3 cause read", d, 32'h0000_0001);
        do_read(2'd0, d); check("R3 cause cleared by read", d, 32'h0);

        // R2 reserved bit 5
        pulse(8'h24);
        do_read(2'd0, d); check("R2 reserved bit ignored", d, 32'h0000_0004);

        // R6 R7 mask set/clear semantics
        do_write(2'd2, 8'h81);
        do_read(2'd2, d); check("R6 mask set readback", d, 32'h81);
        do_write(2'd2, 8'h00);
        do_read(2'd2, d); check("R6 zero bits leave mask", d, 32'h81);
        do_read(2'd3, d); check("R7 clear register reads zero", d, 32'h0);

        // R9 R8 enabled cause
        pulse(8'h80);
        @(negedge clk); check("R9 irq rises", {31'b0, irq}, 32'h1);
        do_read(2'd0, d); check("R8 summary bit set", d, 32'h8000_0080);
        @(negedge clk); check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

        // R9 unmask a pending cause
        pulse(8'h02);
        @(negedge clk); check("R9 masked pending", {31'b0, irq}, 32'h0);
        do_write(2'd2, 8'h02);
        @(negedge clk); check("R9 unmask raises irq", {31'b0, irq}, 32'h1);

        // R7 mask clear
        do_write(2'd3, 8'h02);
        @(negedge clk); check("R7 mask clear drops irq", {31'b0, irq}, 32'h0);
        do_write(2'd3, 8'h00);
        do_read(2'd2, d); check("R7 zero bits leave mask", d, 32'h81);
        do_read(2'd0, d); check("R8 summary clear when masked", d, 32'h0000_0002);

        // R5 force register
        do_write(2'd1, 8'hFF);
        do_read(2'd0, d); check("R5 forced causes", d, 32'h8000_00DF);
        do_read(2'd1, d); check("R5 force register reads zero", d, 32'h0);

        // R4 event during read
        pulse(8'h01);
        @(negedge clk); rd_en = 1; addr = 2'd0; ev = 8'h08;
        @(negedge clk); d = rdata; rd_en = 0; ev = '0;
        check("R4 read returns prior causes", d, 32'h8000_0001);
        do_read(2'd0, d); check("R4 event kept through read", d, 32'h0000_0008);

        // R10 write to cause address ignored
        do_write(2'd0, 8'hFF);
        do_read(2'd0, d); check("R10 cause write ignored", d, 32'h0);
        do_read(2'd2, d); check("R10 mask untouched", d, 32'h81);

        // R1 reset mid-run
        do_write(2'd1, 8'hFF);
        do_write(2'd2, 8'hFF);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        check("R1 irq low after reset", {31'b0, irq}, 32'h0);
        do_read(2'd0, d); check("R1 cause cleared by reset", d, 32'h0);
        do_read(2'd2, d); check("R1 mask cleared by reset", d, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule